// File: doc/BRIEF.md
# Bang-Bang Phase Alignment Controller

This block keeps a local transmit clock phase-aligned with a remote receiver. Once per frame the receiver returns one sampled bit that tells the local side whether its data edge arrived too early or too late. The controller turns each accepted vote into exactly one step command for an external phase shifter: an advance pulse when the local side is late, a retard pulse when it is early. It also keeps a running count of the steps it has issued, modulo one clock period.

When the loop has converged, the returned bits alternate in a random-looking way. The controller keeps a sliding history of recent votes and raises a lock flag when ones and zeros are close to even. It drops the flag when it sees a long run of identical votes, which means the loop has walked off the edge. Votes are taken only while the enable input is high. A two-stage synchronizer releases the asynchronous reset on a clock edge, so vote strobes are accepted from the third clock edge after `rst_n` rises.

Top module: `phase_align_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `step_up` and `step_dn` are low, `phase_pos` is 0 and `locked` is low until votes are accepted.
- R2: A vote is accepted when `vote_valid` and `en` are both high at a clock edge. An accepted vote of 1 (local side late) drives `step_up` high for the single cycle after that edge, and `phase_pos` rises by one in the same cycle.
- R3: An accepted vote of 0 (local side early) drives `step_dn` high for the single cycle after that edge, and `phase_pos` falls by one in the same cycle.
- R4: Each accepted vote makes exactly one step pulse. `step_up` and `step_dn` are never high together, and with no accepted vote in the preceding cycle both are low.
- R5: While `en` is low, strobes have no effect. No step pulse is issued, `phase_pos` and `locked` stay put, and the strobe does not enter the vote history.
- R6: `phase_pos` lies in 0..STEPS-1 (default 6720). A step up from 6719 gives 0.
- R7: A step down from 0 gives 6719.
- R8: Once the history holds WIN (64) accepted votes, `locked` rises after an accepted vote that leaves a ones count strictly between 24 and 40 (|ones - zeros| < 16) in the last 64 votes. A count of 24 or 40 does not lock.
- R9: `locked` stays low until at least 64 votes have been accepted since reset.
- R10: An accepted vote that completes a run of 32 identical consecutive accepted votes clears `locked`. This takes priority over the balance test.
- R11: An unbalanced history without a 32-vote run leaves `locked` unchanged.
- R12: In a closed loop with a receiver whose vote follows the sign of the phase error, the loop reaches lock from reset for any target phase, including one reached through the wrap point. At lock, `phase_pos` is within one step of the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enables vote acceptance |
| vote_valid | input | 1 | One strobe per frame: a returned sample is present |
| vote_bit | input | 1 | Returned sample: 1 = late (advance), 0 = early (retard) |
| step_up | output | 1 | One-cycle phase-advance command |
| step_dn | output | 1 | One-cycle phase-retard command |
| phase_pos | output | 13 | Accumulated step position, modulo STEPS |
| locked | output | 1 | Alignment indicator |

## Verification
The hardest state to reach from the ports is lock acquisition right at the balance limits. The 64-vote history must hold exactly 24, 25, 39 or 40 ones with no long run, and this must happen on the very vote that fills the window. The bench builds such windows with an evenly spread pattern, where vote i is 1 when (i*N mod 64) < N. A second hard case is genuine convergence. Here the bench models a receiver that computes each vote from the current `phase_pos` against a chosen target, so the loop walks across thousands of steps, and for one target across the wrap point, before the votes start to alternate.

// File: rtl/pa_pkg.sv
package pa_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2
  } step_dir_t;
endpackage

// File: rtl/pa_vote_window.sv
module pa_vote_window #(
  parameter int WIN     = 64,
  parameter int BAL_LIM = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic bit_in,
  output logic bal_nxt
);
  localparam int CW = $clog2(WIN + 1);

  logic [WIN-1:0] hist_q, hist_d;
  logic [CW-1:0]  ones_q, ones_d;
  logic [CW-1:0]  fill_q, fill_d;
  logic [CW:0]    twice_ones;

  always_comb begin
    hist_d = hist_q;
    ones_d = ones_q;
    fill_d = fill_q;
    if (accept) begin
      hist_d = {hist_q[WIN-2:0], bit_in};
      ones_d = ones_q + CW'(bit_in) - CW'(hist_q[WIN-1]);
      if (fill_q != CW'(WIN)) begin
        fill_d = fill_q + 1'b1;
      end
    end
  end

  always_comb begin
    twice_ones = {ones_d, 1'b0};
    bal_nxt = (fill_d == CW'(WIN)) &&
              (twice_ones > (CW+1)'(WIN - BAL_LIM)) &&
              (twice_ones < (CW+1)'(WIN + BAL_LIM));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      ones_q <= '0;
      fill_q <= '0;
    end else if (accept) begin
      hist_q <= hist_d;
      ones_q <= ones_d;
      fill_q <= fill_d;
    end
  end
endmodule

// File: rtl/pa_run_detect.sv
module pa_run_detect #(
  parameter int RUN_LIM = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic bit_in,
  output logic hit_nxt
);
  localparam int RW = $clog2(RUN_LIM + 1);

  logic [RW-1:0] run_q, run_d;
  logic          last_q;

  always_comb begin
    run_d = run_q;
    if (accept) begin
      if (run_q != '0 && bit_in == last_q) begin
        run_d = (run_q == RW'(RUN_LIM)) ? run_q : run_q + 1'b1;
      end else begin
        run_d = RW'(1);
      end
    end
    hit_nxt = accept && (run_d >= RW'(RUN_LIM));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      last_q <= 1'b0;
    end else if (accept) begin
      run_q  <= run_d;
      last_q <= bit_in;
    end
  end
endmodule

// File: rtl/pa_phase_accum.sv
module pa_phase_accum
  import pa_pkg::*;
#(
  parameter int STEPS = 6720,
  parameter int PW    = $clog2(STEPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  step_dir_t     dir,
  output logic [PW-1:0] pos
);
  localparam logic [PW-1:0] TOP = PW'(STEPS - 1);

  logic [PW-1:0] pos_q, pos_d;

  always_comb begin
    unique case (dir)
      STEP_UP: pos_d = (pos_q == TOP) ? '0 : pos_q + 1'b1;
      STEP_DN: pos_d = (pos_q == '0) ? TOP : pos_q - 1'b1;
      default: pos_d = pos_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (dir != STEP_NONE) begin
      pos_q <= pos_d;
    end
  end

  assign pos = pos_q;
endmodule

// File: rtl/phase_align_ctrl.sv
module phase_align_ctrl
  import pa_pkg::*;
#(
  parameter int STEPS   = 6720,
  parameter int WIN     = 64,
  parameter int BAL_LIM = 16,
  parameter int RUN_LIM = 32,
  parameter int PW      = $clog2(STEPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          vote_valid,
  input  logic          vote_bit,
  output logic          step_up,
  output logic          step_dn,
  output logic [PW-1:0] phase_pos,
  output logic          locked
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rsync_q;
  logic                   rst_int_n;
  logic                   accept;
  logic                   bal_nxt, hit_nxt;
  step_dir_t              dir_d, dir_q;
  logic                   lock_d, lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= '0;
    end else begin
      rsync_q <= {rsync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_int_n = rsync_q[SYNC_STAGES-1];

  assign accept = vote_valid && en && rst_int_n;

  pa_vote_window #(.WIN(WIN), .BAL_LIM(BAL_LIM)) u_window (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .accept (accept),
    .bit_in (vote_bit),
    .bal_nxt(bal_nxt)
  );

  pa_run_detect #(.RUN_LIM(RUN_LIM)) u_run (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .accept (accept),
    .bit_in (vote_bit),
    .hit_nxt(hit_nxt)
  );

  always_comb begin
    dir_d  = STEP_NONE;
    lock_d = lock_q;
    if (accept) begin
      dir_d = vote_bit ? STEP_UP : STEP_DN;
      if (hit_nxt) begin
        lock_d = 1'b0;
      end else if (bal_nxt) begin
        lock_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      dir_q  <= STEP_NONE;
      lock_q <= 1'b0;
    end else begin
      dir_q  <= dir_d;
      lock_q <= lock_d;
    end
  end

  pa_phase_accum #(.STEPS(STEPS), .PW(PW)) u_accum (
    .clk  (clk),
    .rst_n(rst_int_n),
    .dir  (dir_d),
    .pos  (phase_pos)
  );

  assign step_up = (dir_q == STEP_UP);
  assign step_dn = (dir_q == STEP_DN);
  assign locked  = lock_q;
endmodule

// File: rtl/pa_checker.sv
module pa_checker #(
  parameter int STEPS = 6720,
  parameter int PW    = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          vote_valid,
  input logic          vote_bit,
  input logic          step_up,
  input logic          step_dn,
  input logic [PW-1:0] phase_pos,
  input logic          locked
);
  p_excl_steps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(step_up && step_dn));

  p_step_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up || step_dn) |-> $past(vote_valid && en));

  p_gate_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> (!step_up && !step_dn && $stable(phase_pos) && $stable(locked)));

  p_up_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step_up |-> $past(vote_bit));

  p_dn_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step_dn |-> !$past(vote_bit));

  p_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    phase_pos < PW'(STEPS));

  p_up_move_r6: assert property (@(posedge clk) disable iff (!rst_n)
    step_up |-> (phase_pos == (($past(phase_pos) == PW'(STEPS - 1)) ? '0 : $past(phase_pos) + 1'b1)));

  p_dn_move_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step_dn |-> (phase_pos == (($past(phase_pos) == '0) ? PW'(STEPS - 1) : $past(phase_pos) - 1'b1)));

  p_hold_still_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_up && !step_dn) |-> $stable(phase_pos));

  p_lock_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (locked != $past(locked)) |-> $past(vote_valid && en));
endmodule

bind phase_align_ctrl pa_checker #(.STEPS(STEPS), .PW(PW)) u_pa_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .vote_valid(vote_valid),
  .vote_bit  (vote_bit),
  .step_up   (step_up),
  .step_dn   (step_dn),
  .phase_pos (phase_pos),
  .locked    (locked)
);

// File: tb/tb_phase_align_ctrl.sv
module tb_phase_align_ctrl;
  localparam int STEPS = 6720;
  localparam int PW    = $clog2(STEPS);

  logic          clk;
  logic          rst_n;
  logic          en;
  logic          vote_valid;
  logic          vote_bit;
  logic          step_up;
  logic          step_dn;
  logic [PW-1:0] phase_pos;
  logic          locked;

  int n_checks;
  int n_fails;

  phase_align_ctrl dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .vote_valid(vote_valid),
    .vote_bit  (vote_bit),
    .step_up   (step_up),
    .step_dn   (step_dn),
    .phase_pos (phase_pos),
    .locked    (locked)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    en         = 1'b1;
    vote_valid = 1'b0;
    vote_bit   = 1'b0;
    rst_n      = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic vote(input logic b);
    vote_valid = 1'b1;
    vote_bit   = b;
    @(negedge clk);
    vote_valid = 1'b0;
  endtask

  task automatic t_reset();
    en = 1'b1; vote_valid = 1'b0; vote_bit = 1'b0; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 step_up in reset", int'(step_up), 0);
    check("R1 phase in reset", int'(phase_pos), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 step_dn after reset", int'(step_dn), 0);
    check("R1 locked after reset", int'(locked), 0);
    check("R1 phase after reset", int'(phase_pos), 0);
  endtask

  task automatic t_single_steps();
    do_reset();
    vote(1'b1);
    check("R2 step_up pulse", int'(step_up), 1);
    check("R2 no step_dn", int'(step_dn), 0);
    check("R2 phase +1", int'(phase_pos), 1);
    @(negedge clk);
    check("R4 step_up single cycle", int'(step_up), 0);
    vote(1'b0);
    check("R3 step_dn pulse", int'(step_dn), 1);
    check("R3 no step_up", int'(step_up), 0);
    check("R3 phase -1", int'(phase_pos), 0);
    @(negedge clk);
    check("R4 step_dn single cycle", int'(step_dn), 0);
    vote(1'b1); vote(1'b1); vote(1'b1);
    check("R4 back-to-back steps", int'(phase_pos), 3);
  endtask

  task automatic t_enable_gate();
    do_reset();
    for (int i = 0; i < 70; i++) vote(1'b1);
    check("R5 setup phase", int'(phase_pos), 70);
    en = 1'b0;
    for (int i = 0; i < 40; i++) begin
      vote(1'b0);
      if (step_up || step_dn) check("R5 pulse while disabled", 1, 0);
    end
    check("R5 phase unchanged", int'(phase_pos), 70);
    check("R5 lock unchanged", int'(locked), 0);
    en = 1'b1;
    vote(1'b1);
    check("R5 run kept after gated zeros, lock low", int'(locked), 0);
  endtask

  task automatic t_wrap();
    do_reset();
    vote(1'b0);
    check("R7 wrap 0 to 6719", int'(phase_pos), STEPS - 1);
    check("R7 step_dn at wrap", int'(step_dn), 1);
    vote(1'b1);
    check("R6 wrap 6719 to 0", int'(phase_pos), 0);
  endtask

  task automatic t_balance(input int n_ones, input int exp_lock);
    do_reset();
    for (int i = 0; i < 63; i++) begin
      vote(((i * n_ones) % 64) < n_ones);
      if (locked) check("R9 lock before window full", 1, 0);
    end
    check("R9 no lock at 63 votes", int'(locked), 0);
    vote(((63 * n_ones) % 64) < n_ones);
    check($sformatf("R8 lock with %0d ones", n_ones), int'(locked), exp_lock);
  endtask

  task automatic t_hold_and_run();
    do_reset();
    for (int i = 0; i < 64; i++) vote(i % 2 == 0);
    check("R8 lock on alternating votes", int'(locked), 1);
    for (int i = 0; i < 64; i++) vote((i % 4) != 3);
    check("R11 unbalanced hold", int'(locked), 1);
    for (int i = 0; i < 31; i++) vote(1'b1);
    check("R10 31-run keeps lock", int'(locked), 1);
    vote(1'b1);
    check("R10 32-run clears lock", int'(locked), 0);
  endtask

  task automatic t_converge(input int target);
    int cyc;
    int diff;
    int err;
    do_reset();
    cyc = 0;
    while (!locked && cyc < 8000) begin
      diff = (target - int'(phase_pos) + STEPS) % STEPS;
      vote(diff >= 1 && diff <= STEPS / 2);
      cyc++;
    end
    check($sformatf("R12 lock reached for target %0d", target), int'(locked), 1);
    err = (int'(phase_pos) - target + STEPS) % STEPS;
    if (err > STEPS / 2) err = STEPS - err;
    check($sformatf("R12 phase error steps target %0d", target), int'(err <= 1), 1);
  endtask

  initial begin
    #(150000 * 5);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    n_checks = 0;
    n_fails  = 0;
    t_reset();
    t_single_steps();
    t_enable_gate();
    t_wrap();
    t_balance(24, 0);
    t_balance(25, 1);
    t_balance(39, 1);
    t_balance(40, 0);
    t_hold_and_run();
    t_converge(3000);
    t_converge(5000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule